// File: doc/BRIEF.md
# Relocatable Address Window Decoder

This block watches a 16-bit processor address bus and decodes two windows whose positions can be moved. The first window is a 1K-byte control page. It holds the two window-position registers, six general-purpose byte registers and a 16-byte scratch RAM. The second window is an 8K-byte region that belongs to an external nonvolatile memory array. The block only raises a select for that region and does not serve its data.

Each window's position comes from its own map register. The page map register holds the upper six address bits of the control page. The array map register holds the upper three address bits of the array window, plus a lock flag and a reset-control flag that are stored and have no other effect here. Both map registers behave as nonvolatile storage. The reset input does not touch them, and they change only while the nonvolatile write enable is high. When read, both return the bitwise complement of what they store.

Every access is sampled on a rising clock edge. The two selects and the read data are registered and appear one cycle after the access.

Top module: `addr_window_decoder`

## Requirements
- R1: One cycle after an enabled access whose address bits 15..10 equal the 6-bit page field, `reg_sel` is 1.
- R2: One cycle after an enabled access whose address bits 15..13 equal array-map bits 2..0, and that misses the control page, `mem_sel` is 1. Otherwise `mem_sel` is 0.
- R3: When an address falls in both windows, only `reg_sel` is asserted and `mem_sel` stays 0.
- R4: Before any map write, the page field is 0x3F, so the page spans 0xFC00..0xFFFF. The array map starts as the parameter value, which is 0x00 by default.
- R5: The page map register sits at page offset 0x00 and the array map register at offset 0x38. Reading either returns the complement of the stored byte. Stored bits 7..6 of the page map are always 0. Stored array-map bits 7, 6 and 4 are always 0, and it keeps bit 5 (lock), bit 3 (reset flag) and bits 2..0 (window field).
- R6: A write to either map register has no effect while `nv_wen` is 0.
- R7: Asserting `rst` leaves both map registers unchanged.
- R8: Offsets 0x08, 0x10, 0x18, 0x20, 0x28 and 0x30 are read/write byte registers, and `rst` clears them to 0x00.
- R9: Offsets 0x200..0x20F are a 16-byte read/write scratch RAM.
- R10: A page offset that is not a map register, a general register or a scratch RAM location reads as 0x00, and a write to it changes no stored value.
- R11: A map write with `nv_wen` high moves the window for the access in the very next cycle.
- R12: In the cycle after a cycle with no page read (an idle cycle, a write, or an access outside the page), `rdata` is 0x00. After an idle cycle both selects are also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset (does not affect the map registers) |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Processor address |
| bus_wdata | input | 8 | Write data |
| nv_wen | input | 1 | Nonvolatile write enable for the map registers |
| reg_sel | output | 1 | Registered control-page select |
| mem_sel | output | 1 | Registered array-window select |
| rdata | output | 8 | Registered read data from the page |

## Verification
An access presented in one cycle produces its `reg_sel`, `mem_sel` and `rdata` result exactly one clock edge later. The bench sets up each access on a falling edge and reads the outputs on the next falling edge, so each sample falls halfway between the edge that captures the access and the following edge. The bench runs accesses back to back with no idle cycle between them. As a result, a map write followed at once by an access checks that the moved window is in force in the very next cycle. It also checks that each stored value holds through the cycles in between.

// File: rtl/awd_pkg.sv
package awd_pkg;
  // page offset of the scratch RAM, and the register slots that need special handling
  localparam int unsigned RAM_OFFSET   = 32'h200;
  localparam int unsigned SLOT_PAGEMAP = 0;
  localparam int unsigned SLOT_MEMMAP  = 7;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_REG  = 2'd1,
    SRC_RAM  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/awd_map_regs.sv
module awd_map_regs #(
  parameter int             DATA_W        = 8,
  parameter int             PAGE_BITS     = 6,
  parameter int             MEM_BITS      = 3,
  parameter logic [7:0]     PAGE_MAP_INIT = 8'h3F,
  parameter logic [7:0]     MEM_MAP_INIT  = 8'h00
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 nv_wen,
  input  logic                 wr_page,
  input  logic                 wr_mem,
  input  logic [DATA_W-1:0]    wdata,
  output logic [PAGE_BITS-1:0] page_base,
  output logic [MEM_BITS-1:0]  mem_base,
  output logic [DATA_W-1:0]    page_rd,
  output logic [DATA_W-1:0]    mem_rd
);
  // array map keeps lock (bit 5), reset flag (bit 3) and window field (low bits)
  localparam logic [DATA_W-1:0] MEM_KEEP =
    DATA_W'(8'h28) | DATA_W'((1 << MEM_BITS) - 1);

  // nonvolatile storage: power-up value only, no reset branch
  logic [PAGE_BITS-1:0] page_q = PAGE_MAP_INIT[PAGE_BITS-1:0];
  logic [DATA_W-1:0]    mem_q  = DATA_W'(MEM_MAP_INIT) & MEM_KEEP;

  always_ff @(posedge clk) begin
    if (nv_wen && wr_page) page_q <= wdata[PAGE_BITS-1:0];
    if (nv_wen && wr_mem)  mem_q  <= wdata & MEM_KEEP;
  end

  assign page_base = page_q;
  assign mem_base  = mem_q[MEM_BITS-1:0];
  assign page_rd   = ~DATA_W'(page_q);
  assign mem_rd    = ~mem_q;

  // R6: without the nonvolatile enable neither map moves
  a_r6_map_locked: assert property (@(posedge clk) disable iff (rst)
    !nv_wen |=> ($stable(page_base) && $stable(mem_rd)));
endmodule

// File: rtl/awd_window_match.sv
module awd_window_match #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 6,
  parameter int MEM_BITS  = 3
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [PAGE_BITS-1:0] page_base,
  input  logic [MEM_BITS-1:0]  mem_base,
  output logic                 page_hit,
  output logic                 mem_hit
);
  logic raw_mem;
  always_comb begin
    page_hit = (addr[ADDR_W-1 -: PAGE_BITS] == page_base);
    raw_mem  = (addr[ADDR_W-1 -: MEM_BITS] == mem_base);
    // control page has priority over the array window
    mem_hit  = raw_mem && !page_hit;
  end
endmodule

// File: rtl/awd_gp_regs.sv
module awd_gp_regs #(
  parameter int DATA_W   = 8,
  parameter int GP_COUNT = 6,
  parameter int IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] regs [GP_COUNT];

  // slot g+1 of the page holds general register g
  for (genvar g = 0; g < GP_COUNT; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                               regs[g] <= '0;
      else if (we && idx == IDX_W'(g + 1))   regs[g] <= wdata;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < GP_COUNT; k++)
      if (idx == IDX_W'(k + 1)) rd_data = regs[k];
  end

  // R8: register contents move only on an enabled write
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(regs[0]) && $stable(regs[GP_COUNT-1]));
endmodule

// File: rtl/awd_scratch_ram.sv
module awd_scratch_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  // single port, synchronous read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata_q <= mem[addr];
  end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int         ADDR_W        = 16,
  parameter int         DATA_W        = 8,
  parameter int         PAGE_BITS     = 6,
  parameter int         MEM_BITS      = 3,
  parameter int         GP_COUNT      = 6,
  parameter int         RAM_DEPTH     = 16,
  parameter logic [7:0] PAGE_MAP_INIT = 8'h3F,
  parameter logic [7:0] MEM_MAP_INIT  = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [15:0]       bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              nv_wen,
  output logic              reg_sel,
  output logic              mem_sel,
  output logic [DATA_W-1:0] rdata
);
  import awd_pkg::*;

  localparam int OFF_W  = ADDR_W - PAGE_BITS;
  localparam int IDX_W  = 3;
  localparam int STRIDE = 3;                  // 8-byte register spacing
  localparam int RAM_AW = $clog2(RAM_DEPTH);

  logic [OFF_W-1:0]     offset;
  logic [PAGE_BITS-1:0] page_base;
  logic [MEM_BITS-1:0]  mem_base;
  logic [DATA_W-1:0]    page_rd, mem_rd, gp_rd, ram_q, slot_val;
  logic                 page_hit, mem_hit;
  logic                 slot_hit, ram_hit, wr_acc, rd_acc;
  logic [IDX_W-1:0]     slot;

  logic                 reg_sel_q, mem_sel_q;
  logic [DATA_W-1:0]    misc_q;
  rd_src_e              src_q;

  awd_window_match #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .MEM_BITS(MEM_BITS))
  u_match (
    .addr(bus_addr), .page_base(page_base), .mem_base(mem_base),
    .page_hit(page_hit), .mem_hit(mem_hit)
  );

  // decode of the offset inside the control page
  always_comb begin
    offset   = bus_addr[OFF_W-1:0];
    slot_hit = page_hit && (offset[OFF_W-1:STRIDE+IDX_W] == '0)
                        && (offset[STRIDE-1:0] == '0);
    slot     = offset[STRIDE+IDX_W-1:STRIDE];
    ram_hit  = page_hit && (offset[OFF_W-1:RAM_AW] == OFF_W'(RAM_OFFSET) >> RAM_AW);
    wr_acc   = bus_en && bus_we;
    rd_acc   = bus_en && !bus_we && page_hit;
  end

  awd_map_regs #(
    .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS), .MEM_BITS(MEM_BITS),
    .PAGE_MAP_INIT(PAGE_MAP_INIT), .MEM_MAP_INIT(MEM_MAP_INIT)
  ) u_maps (
    .clk(clk), .rst(rst), .nv_wen(nv_wen),
    .wr_page(wr_acc && slot_hit && slot == IDX_W'(SLOT_PAGEMAP)),
    .wr_mem (wr_acc && slot_hit && slot == IDX_W'(SLOT_MEMMAP)),
    .wdata(bus_wdata), .page_base(page_base), .mem_base(mem_base),
    .page_rd(page_rd), .mem_rd(mem_rd)
  );

  awd_gp_regs #(.DATA_W(DATA_W), .GP_COUNT(GP_COUNT), .IDX_W(IDX_W)) u_gp (
    .clk(clk), .rst(rst), .we(wr_acc && slot_hit), .idx(slot),
    .wdata(bus_wdata), .rd_data(gp_rd)
  );

  awd_scratch_ram #(.DATA_W(DATA_W), .DEPTH(RAM_DEPTH)) u_ram (
    .clk(clk), .we(wr_acc && ram_hit), .addr(offset[RAM_AW-1:0]),
    .wdata(bus_wdata), .rdata_q(ram_q)
  );

  always_comb begin
    if (!slot_hit)                              slot_val = '0;
    else if (slot == IDX_W'(SLOT_PAGEMAP))      slot_val = page_rd;
    else if (slot == IDX_W'(SLOT_MEMMAP))       slot_val = mem_rd;
    else                                        slot_val = gp_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_sel_q <= 1'b0;
      mem_sel_q <= 1'b0;
      misc_q    <= '0;
      src_q     <= SRC_NONE;
    end else begin
      reg_sel_q <= bus_en && page_hit;
      mem_sel_q <= bus_en && mem_hit;
      misc_q    <= rd_acc ? slot_val : '0;
      if (!rd_acc)      src_q <= SRC_NONE;
      else if (ram_hit) src_q <= SRC_RAM;
      else              src_q <= SRC_REG;
    end
  end

  assign reg_sel = reg_sel_q;
  assign mem_sel = mem_sel_q;
  assign rdata   = (src_q == SRC_RAM) ? ram_q : misc_q;

  // R1: a matching page address is selected one cycle later
  a_r1_page_sel: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_addr[ADDR_W-1 -: PAGE_BITS] == page_base) |=> reg_sel);

  // R2: an array address outside the page is selected one cycle later
  a_r2_mem_sel: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_addr[ADDR_W-1 -: MEM_BITS] == mem_base
            && bus_addr[ADDR_W-1 -: PAGE_BITS] != page_base) |=> mem_sel);

  // R3: the two selects never rise together
  a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(reg_sel && mem_sel));

  // R12: an idle cycle leaves everything quiet
  a_r12_idle: assert property (@(posedge clk) disable iff (rst)
    !bus_en |=> (!reg_sel && !mem_sel && rdata == '0));

  // R10: an offset in the unused middle of the page reads as zero
  a_r10_hole: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we && bus_addr[ADDR_W-1 -: PAGE_BITS] == page_base
            && bus_addr[9:8] == 2'b01) |=> rdata == '0);
endmodule

// File: tb/addr_window_decoder_tb.sv
module addr_window_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0, nv_wen = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        reg_sel, mem_sel;
  logic [7:0]  rdata;

  int checks = 0;
  int errors = 0;
  logic o_reg, o_mem;
  logic [7:0] o_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_window_decoder u_dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .nv_wen(nv_wen),
    .reg_sel(reg_sel), .mem_sel(mem_sel), .rdata(rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one access from a falling edge, capture the outputs at the next one
  task automatic cyc(input logic en, input logic we, input logic [15:0] a,
                     input logic [7:0] d, input logic nv);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d; nv_wen = nv;
    @(negedge clk);
    o_reg = reg_sel; o_mem = mem_sel; o_data = rdata;
    bus_en = 1'b0; bus_we = 1'b0; nv_wen = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a); cyc(1'b1, 1'b0, a, 8'h00, 1'b0); endtask
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic nv);
    cyc(1'b1, 1'b1, a, d, nv);
  endtask

  task automatic pulse_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_power_up();
    cyc(1'b0, 1'b0, 16'h0000, 8'h00, 1'b0);
    chk("R12 idle reg_sel", o_reg, 0); chk("R12 idle mem_sel", o_mem, 0);
    chk("R12 idle rdata", o_data, 0);
    rd(16'hFC00);
    chk("R4 page at FC00", o_reg, 1); chk("R5 page map readback", o_data, 8'hC0);
    rd(16'hFC38); chk("R5 array map readback", o_data, 8'hFF);
    rd(16'hFC08); chk("R8 gp reset value", o_data, 8'h00);
    rd(16'hFBFF); chk("R1 below page no select", o_reg, 0);
  endtask

  task automatic t_array_window();
    rd(16'h0123); chk("R2 array select", o_mem, 1); chk("R2 no page select", o_reg, 0);
    chk("R12 array read data", o_data, 0);
    rd(16'h4000); chk("R2 outside both", o_mem, 0);
  endtask

  task automatic t_gp_regs();
    wr(16'hFC08, 8'h5A, 1'b0);
    chk("R12 write rdata", o_data, 0);
    wr(16'hFC30, 8'hA5, 1'b0);
    rd(16'hFC08); chk("R8 reg 0x08", o_data, 8'h5A);
    rd(16'hFC30); chk("R8 reg 0x30", o_data, 8'hA5);
    wr(16'hFC0C, 8'h77, 1'b0);
    rd(16'hFC0C); chk("R10 undefined reads zero", o_data, 0);
    rd(16'hFC08); chk("R10 neighbour untouched", o_data, 8'h5A);
    rd(16'hFD00); chk("R10 hole reads zero", o_data, 0);
  endtask

  task automatic t_sram();
    wr(16'hFE00, 8'h11, 1'b0);
    wr(16'hFE0F, 8'hEE, 1'b0);
    rd(16'hFE00); chk("R9 ram first", o_data, 8'h11);
    rd(16'hFE0F); chk("R9 ram last", o_data, 8'hEE);
    wr(16'hFE10, 8'h99, 1'b0);
    rd(16'hFE10); chk("R10 past ram zero", o_data, 0);
    rd(16'hFE00); chk("R10 ram not aliased", o_data, 8'h11);
  endtask

  task automatic t_nv_lock();
    wr(16'hFC00, 8'h10, 1'b0);
    rd(16'hFC00); chk("R6 page map unchanged", o_data, 8'hC0);
    wr(16'hFC38, 8'h07, 1'b0);
    rd(16'hFC38); chk("R6 array map unchanged", o_data, 8'hFF);
  endtask

  task automatic t_relocate();
    wr(16'hFC00, 8'hD0, 1'b1);                 // field 0x10 -> 0x4000
    rd(16'h4000); chk("R11 moved next cycle", o_reg, 1);
    chk("R5 bits 7..6 stored zero", o_data, 8'hEF);
    rd(16'hFC00); chk("R11 old page gone", o_reg, 0); chk("R11 old page data", o_data, 0);
    wr(16'h4038, 8'hFF, 1'b1);                 // keeps 0x2F, window 0xE000
    rd(16'h4038); chk("R5 array map masked", o_data, 8'hD0);
    rd(16'hE000); chk("R2 array moved", o_mem, 1);
    wr(16'h4000, 8'h3F, 1'b1);                 // page back into array range
    rd(16'hFC10); chk("R3 page wins reg_sel", o_reg, 1); chk("R3 array held low", o_mem, 0);
    rd(16'hF000); chk("R3 array outside page", o_mem, 1);
  endtask

  task automatic t_reset_keeps_maps();
    wr(16'hFC00, 8'h20, 1'b1);                 // page -> 0x8000
    wr(16'h8008, 8'h33, 1'b0);
    pulse_reset();
    rd(16'h8000); chk("R7 page survives reset", o_reg, 1);
    chk("R7 page value kept", o_data, 8'hDF);
    rd(16'h8038); chk("R7 array map kept", o_data, 8'hD0);
    rd(16'h8008); chk("R8 gp cleared by reset", o_data, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    pulse_reset();
    t_power_up();
    t_array_window();
    t_gp_regs();
    t_sram();
    t_nv_lock();
    t_relocate();
    t_reset_keeps_maps();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule